// File: doc/BRIEF.md
# Supervisor Low-Memory Access Guard

This block is the address-protection stage between a CPU bus master and the memory targets. For each bus cycle it looks at the address, the transfer direction and the privilege flag. It then does one of two things: it selects ROM, RAM or I/O, or it refuses the cycle with a bus error. All protection is fixed decode logic at byte granularity. There are no translation pages.

Four rules apply:
- Address zero holds a small ROM shadow that carries the reset stack pointer and start address. Only a supervisor may read it, and nobody may write it.
- The rest of the first 2 KB is the vector table and supervisor stack in RAM. Only a supervisor may use it.
- The same 2 KB low image also appears at a high alias base, with the same rules.
- The I/O window is for the supervisor only, and every ROM location is read-only in both modes.

The decision is registered. It appears one clock after the strobe is sampled and clears one clock after the strobe drops.

Top module: `lowmem_guard`

## Requirements
- R1: While `rst` is high, every select and `bus_err` are low on the following clock.
- R2: When `cpu_strobe` is low at a clock edge, every select and `bus_err` are low after that edge.
- R3: The verdict for a cycle with `cpu_strobe` high appears on the outputs one clock after it is sampled. The verdict is one of: ROM select, RAM select, I/O select, bus error, or nothing.
- R4: In the ROM shadow (bytes 0x0 to 0x7 of an image), a supervisor read asserts `rom_cs`. A user read asserts `bus_err`. Any write asserts `bus_err`.
- R5: In bytes 0x8 to 0x7FF of an image, a supervisor read or write asserts `ram_cs`. Any user access asserts `bus_err`.
- R6: The image at 0xFF000000 to 0xFF0007FF obeys R4 and R5 with offsets taken from 0xFF000000. 0xFF000800 is outside the image.
- R7: RAM from 0x800 up to `RAM_BYTES`-1 asserts `ram_cs` for reads and writes in both modes, with no error.
- R8: In the ROM window (default 0x00E00000 to 0x00EFFFFF), a read in either mode asserts `rom_cs`. A write in either mode asserts `bus_err`.
- R9: In the I/O window (default 0x00FF8000 to 0x00FFFFFF), a supervisor access asserts `io_cs`. A user access asserts `bus_err`.
- R10: While `bus_err` is high, no select is high. At most one select is high at any time.
- R11: Once `bus_err` is high, it stays high while `cpu_strobe` stays high, even if the address changes. It clears on the clock after the strobe drops.
- R12: An address in no region (for example `RAM_BYTES`, 0x00F00000, 0xFF000800) asserts no select and no bus error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 32 | Byte address of the bus cycle |
| cpu_strobe | input | 1 | High while a bus cycle is in progress |
| cpu_read | input | 1 | 1 = read, 0 = write |
| cpu_super | input | 1 | 1 = supervisor mode, 0 = user mode |
| rom_cs | output | 1 | ROM chip select (registered) |
| ram_cs | output | 1 | RAM chip select (registered) |
| io_cs | output | 1 | I/O chip select (registered) |
| bus_err | output | 1 | Bus error to the master (registered) |

## Verification
The assertions check four properties on every cycle:
- error and selects are mutually exclusive, and at most one select is high;
- outputs go idle after reset or after a dropped strobe;
- an error holds while the strobe stays high;
- a user cycle never reaches I/O, and a write never reaches ROM.

Per-region correctness needs the bench's scenarios. These cover the exact split at 0x7/0x8, 0x7FF/0x800 and the ROM, I/O and RAM edges, the high alias, and unmapped holes. Each address is driven with all four direction and privilege pairs and compared against a reference model.

// File: rtl/lowmem_guard_pkg.sv
package lowmem_guard_pkg;
  typedef enum logic [2:0] {
    RG_NONE,
    RG_SHADOW,
    RG_VECTOR,
    RG_RAM,
    RG_ROM,
    RG_IO
  } region_e;

  typedef struct packed {
    logic rom;
    logic ram;
    logic io;
    logic err;
  } verdict_t;

  localparam verdict_t VERDICT_IDLE = '{rom: 1'b0, ram: 1'b0, io: 1'b0, err: 1'b0};
endpackage

// File: rtl/lmg_region_decode.sv
module lmg_region_decode
  import lowmem_guard_pkg::*;
#(
  parameter logic [31:0] ROM_BASE     = 32'h00E0_0000,
  parameter logic [31:0] ROM_BYTES    = 32'h0010_0000,
  parameter logic [31:0] IO_BASE      = 32'h00FF_8000,
  parameter logic [31:0] IO_BYTES     = 32'h0000_8000,
  parameter logic [31:0] RAM_BYTES    = 32'h0040_0000,
  parameter logic [31:0] HI_BASE      = 32'hFF00_0000,
  parameter int          LOW_BYTES    = 2048,
  parameter int          SHADOW_BYTES = 8
) (
  input  logic [31:0] addr,
  output region_e     region
);
  localparam int LOW_AW = $clog2(LOW_BYTES);
  localparam int SH_AW  = $clog2(SHADOW_BYTES);
  localparam int N_IMG  = 2;

  logic [N_IMG-1:0] img_hit;
  logic             in_shadow_off;
  logic             in_rom, in_io, in_ram;

  assign in_shadow_off = (addr[LOW_AW-1:SH_AW] == '0);

  for (genvar g = 0; g < N_IMG; g++) begin : g_img
    localparam logic [31:0] IMG_BASE = (g == 0) ? 32'h0 : HI_BASE;
    assign img_hit[g] = ((addr >> LOW_AW) == (IMG_BASE >> LOW_AW));
  end

  assign in_rom = (addr >= ROM_BASE) && ((addr - ROM_BASE) < ROM_BYTES);
  assign in_io  = (addr >= IO_BASE)  && ((addr - IO_BASE)  < IO_BYTES);
  assign in_ram = (addr < RAM_BYTES);

  always_comb begin
    if (|img_hit)    region = in_shadow_off ? RG_SHADOW : RG_VECTOR;
    else if (in_io)  region = RG_IO;
    else if (in_rom) region = RG_ROM;
    else if (in_ram) region = RG_RAM;
    else             region = RG_NONE;
  end
endmodule

// File: rtl/lmg_policy.sv
module lmg_policy
  import lowmem_guard_pkg::*;
(
  input  region_e  region,
  input  logic     rd,
  input  logic     sup,
  output verdict_t verdict
);
  always_comb begin
    verdict = VERDICT_IDLE;
    unique case (region)
      RG_SHADOW: begin
        if (rd && sup) verdict.rom = 1'b1;
        else           verdict.err = 1'b1;
      end
      RG_VECTOR: begin
        if (sup) verdict.ram = 1'b1;
        else     verdict.err = 1'b1;
      end
      RG_RAM: verdict.ram = 1'b1;
      RG_ROM: begin
        if (rd) verdict.rom = 1'b1;
        else    verdict.err = 1'b1;
      end
      RG_IO: begin
        if (sup) verdict.io  = 1'b1;
        else     verdict.err = 1'b1;
      end
      default: verdict = VERDICT_IDLE;
    endcase
  end
endmodule

// File: rtl/lowmem_guard.sv
module lowmem_guard
  import lowmem_guard_pkg::*;
#(
  parameter logic [31:0] ROM_BASE     = 32'h00E0_0000,
  parameter logic [31:0] ROM_BYTES    = 32'h0010_0000,
  parameter logic [31:0] IO_BASE      = 32'h00FF_8000,
  parameter logic [31:0] IO_BYTES     = 32'h0000_8000,
  parameter logic [31:0] RAM_BYTES    = 32'h0040_0000,
  parameter logic [31:0] HI_BASE      = 32'hFF00_0000,
  parameter int          LOW_BYTES    = 2048,
  parameter int          SHADOW_BYTES = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] cpu_addr,
  input  logic        cpu_strobe,
  input  logic        cpu_read,
  input  logic        cpu_super,
  output logic        rom_cs,
  output logic        ram_cs,
  output logic        io_cs,
  output logic        bus_err
);
  region_e  region;
  verdict_t verdict_d, verdict_q;

  lmg_region_decode #(
    .ROM_BASE(ROM_BASE), .ROM_BYTES(ROM_BYTES), .IO_BASE(IO_BASE),
    .IO_BYTES(IO_BYTES), .RAM_BYTES(RAM_BYTES), .HI_BASE(HI_BASE),
    .LOW_BYTES(LOW_BYTES), .SHADOW_BYTES(SHADOW_BYTES)
  ) u_decode (
    .addr  (cpu_addr),
    .region(region)
  );

  lmg_policy u_policy (
    .region (region),
    .rd     (cpu_read),
    .sup    (cpu_super),
    .verdict(verdict_d)
  );

  always_ff @(posedge clk) begin
    if (rst || !cpu_strobe) begin
      verdict_q <= VERDICT_IDLE;
    end else if (verdict_q.err) begin
      verdict_q <= '{rom: 1'b0, ram: 1'b0, io: 1'b0, err: 1'b1};
    end else begin
      verdict_q <= verdict_d;
    end
  end

  assign rom_cs  = verdict_q.rom;
  assign ram_cs  = verdict_q.ram;
  assign io_cs   = verdict_q.io;
  assign bus_err = verdict_q.err;

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> !(rom_cs || ram_cs || io_cs || bus_err));

  p_strobe_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !cpu_strobe |=> !(rom_cs || ram_cs || io_cs || bus_err));

  p_err_no_cs_r10: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> !(rom_cs || ram_cs || io_cs));

  p_cs_onehot_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rom_cs, ram_cs, io_cs}));

  p_err_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (cpu_strobe && bus_err) |=> bus_err);

  p_user_no_io_r9: assert property (@(posedge clk) disable iff (rst)
    (cpu_strobe && !cpu_super) |=> !io_cs);

  p_write_no_rom_r8: assert property (@(posedge clk) disable iff (rst)
    (cpu_strobe && !cpu_read) |=> !rom_cs);
endmodule

// File: tb/lowmem_guard_test.sv
module lowmem_guard_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] cpu_addr = '0;
  logic        cpu_strobe = 1'b0;
  logic        cpu_read = 1'b1;
  logic        cpu_super = 1'b0;
  logic        rom_cs, ram_cs, io_cs, bus_err;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit done    = 1'b0;

  typedef struct {
    logic [3:0] exp;
    int         due;
    string      tag;
    logic [31:0] addr;
  } item_t;
  item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lowmem_guard uut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_strobe(cpu_strobe),
    .cpu_read(cpu_read), .cpu_super(cpu_super),
    .rom_cs(rom_cs), .ram_cs(ram_cs), .io_cs(io_cs), .bus_err(bus_err)
  );

  // Reference model: returns {rom, ram, io, err}
  function automatic logic [3:0] ref_model(logic [31:0] a, logic rd, logic sup);
    logic [31:0] off;
    bit img;
    img = (a < 32'h800) || (a >= 32'hFF00_0000 && a < 32'hFF00_0800);
    off = a & 32'h7FF;
    if (img && off < 8)                          return (rd && sup) ? 4'b1000 : 4'b0001;
    if (img)                                     return sup ? 4'b0100 : 4'b0001;
    if (a >= 32'h00FF_8000 && a <= 32'h00FF_FFFF) return sup ? 4'b0010 : 4'b0001;
    if (a >= 32'h00E0_0000 && a <= 32'h00EF_FFFF) return rd ? 4'b1000 : 4'b0001;
    if (a < 32'h0040_0000)                       return 4'b0100;
    return 4'b0000;
  endfunction

  function automatic string ref_tag(logic [31:0] a);
    logic [31:0] off;
    bit img;
    bit hi;
    hi  = (a >= 32'hFF00_0000 && a < 32'hFF00_0800);
    img = (a < 32'h800) || hi;
    off = a & 32'h7FF;
    if (img && off < 8) return hi ? "R6/R4" : "R4";
    if (img)            return hi ? "R6/R5" : "R5";
    if (a >= 32'h00FF_8000 && a <= 32'h00FF_FFFF) return "R9";
    if (a >= 32'h00E0_0000 && a <= 32'h00EF_FFFF) return "R8";
    if (a < 32'h0040_0000) return "R7";
    return "R12";
  endfunction

  task automatic push(logic [3:0] e, string t, logic [31:0] a);
    item_t it;
    it.exp = e; it.due = cyc + 1; it.tag = t; it.addr = a;
    sb.push_back(it);
  endtask

  // One cycle of strobe, then one idle cycle (R3, R2)
  task automatic access(logic [31:0] a, logic rd, logic sup);
    @(negedge clk);
    cpu_addr = a; cpu_read = rd; cpu_super = sup; cpu_strobe = 1'b1;
    push(ref_model(a, rd, sup), {ref_tag(a), " R3"}, a);
    @(negedge clk);
    cpu_strobe = 1'b0;
    push(4'b0000, "R2 idle", a);
  endtask

  // Monitor: compare at negedges when an item is due
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due == cyc) begin
      item_t it;
      logic [3:0] act;
      it  = sb.pop_front();
      act = {rom_cs, ram_cs, io_cs, bus_err};
      n_tests++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s addr=%h actual=%b expected=%b", it.tag, it.addr, act, it.exp);
      end
    end
  end

  initial begin
    logic [31:0] addrs [19];
    addrs = '{32'h0, 32'h7, 32'h8, 32'h7FF, 32'h800, 32'h003F_FFFF, 32'h0040_0000,
              32'h00DF_FFFF, 32'h00E0_0000, 32'h00EF_FFFF, 32'h00F0_0000,
              32'h00FF_7FFF, 32'h00FF_8000, 32'h00FF_FFFF, 32'hFF00_0000,
              32'hFF00_0007, 32'hFF00_0008, 32'hFF00_07FF, 32'hFF00_0800};
    repeat (3) @(negedge clk);
    n_tests++;
    if ({rom_cs, ram_cs, io_cs, bus_err} !== 4'b0000) begin
      n_fail++;
      $display("FAIL R1 reset actual=%b expected=0000", {rom_cs, ram_cs, io_cs, bus_err});
    end
    rst = 1'b0;
    foreach (addrs[i]) begin
      for (int m = 0; m < 4; m++) access(addrs[i], m[0], m[1]);
    end
    // R11: error held across an address change while strobe stays high
    @(negedge clk);
    cpu_addr = 32'h00FF_8000; cpu_read = 1'b1; cpu_super = 1'b0; cpu_strobe = 1'b1;
    push(4'b0001, "R11 first", cpu_addr);
    @(negedge clk);
    cpu_addr = 32'h0000_1000; cpu_super = 1'b1;
    push(4'b0001, "R11 hold", cpu_addr);
    @(negedge clk);
    push(4'b0001, "R11 hold2", cpu_addr);
    @(negedge clk);
    cpu_strobe = 1'b0;
    push(4'b0000, "R11 clear", cpu_addr);
    @(negedge clk);
    cpu_strobe = 1'b1;
    push(4'b0100, "R11 next cycle", cpu_addr);
    @(negedge clk);
    cpu_strobe = 1'b0;
    push(4'b0000, "R2 idle", cpu_addr);
    // R1: reset during an active cycle
    @(negedge clk);
    cpu_strobe = 1'b1; rst = 1'b1;
    push(4'b0000, "R1 reset active", cpu_addr);
    @(negedge clk);
    rst = 1'b0; cpu_strobe = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    if (sb.size() != 0) begin
      n_tests++;
      n_fail++;
      $display("FAIL scoreboard actual=%0d left expected=0", sb.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule